// File: doc/BRIEF.md
# Associative Key Lookup Table with Priority Hit Selection

This block is an associative lookup table. It holds a fixed number of entries. Each entry has a key, a valid flag and a data word kept in a companion data RAM. When a search is strobed, the presented key is compared against every stored key in the same cycle. Each entry raises its own match flag only when it is valid and every key bit is equal. A priority stage reduces the match flags to one winning entry. The winner's one-hot grant line acts directly as the word select of the data RAM, so the associated data (routing information, for example) comes out with no separate address decode.

Entries are loaded through a plain write port addressed by entry index. The same port clears the valid flag to retire an entry. Search results are registered. The hit flag, the winning index and the associated data appear one clock after the search strobe and are held until the next search.

Top module: `assoc_lookup`

## Requirements
- R1: After reset, hitOut, hitIdx and hitData are all zero and every entry is invalid, so a search for any key, including all zeros, misses.
- R2: When srchEn is high at a rising clock edge and a valid entry holds a key equal to srchKey, the outputs after that same edge are hitOut=1, hitIdx=the entry's binary index and hitData=that entry's data word.
- R3: A key that differs from a stored key in any single bit, whether the stored bit is 1 and the key bit is 0 or the reverse, does not match that entry.
- R4: When several valid entries match, the entry with the lowest index wins and supplies both hitIdx and hitData.
- R5: An entry whose valid flag is 0 never matches. Writing with wrValid=0 retires an entry, and a lower-priority match then wins.
- R6: A search that matches no entry gives hitOut=0, hitIdx=0 and hitData=0.
- R7: A write strobed in the same cycle as a search does not change that search's result, which reflects the table contents before the write. The write is seen by the next search.
- R8: In cycles without srchEn, hitOut, hitIdx and hitData keep their values, even when srchKey changes.
- R9: A write to one entry replaces that entry's key, data and valid flag and leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one entry |
| wrIdx | input | IDX_W | Entry index written |
| wrKey | input | KEY_W | Key stored in the entry |
| wrData | input | DATA_W | Data word stored in the companion RAM |
| wrValid | input | 1 | Valid flag stored in the entry |
| srchEn | input | 1 | Search strobe |
| srchKey | input | KEY_W | Key searched for |
| hitOut | output | 1 | Registered hit flag |
| hitIdx | output | IDX_W | Registered winning entry index, zero on a miss |
| hitData | output | DATA_W | Registered data of the winning entry, zero on a miss |

## Verification
Searches use exact keys, keys with one bit flipped in each direction, and keys held by two entries at once. The flipped-bit keys show whether the comparison is a true per-bit equality or only a partial one. The shared keys show whether the lowest index wins, and the same entries retired one at a time show that the valid flag is honoured. A write and a search in the same cycle, followed by a repeat search, show which table contents a search sees. Idle cycles with a changing key show that results are held between searches.

// File: rtl/assoc_lookup_pkg.sv
package assoc_lookup_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic storeEntry;   // update one entry this cycle
    logic runSearch;    // compare and capture result this cycle
  } lookupStrobes_t;

endpackage

// File: rtl/lookup_ctrl.sv
module lookup_ctrl
  import assoc_lookup_pkg::*;
(
  input  logic           wrEn,
  input  logic           srchEn,
  output lookupStrobes_t strobes
);

  always_comb begin
    strobes            = '0;
    strobes.storeEntry = wrEn;
    strobes.runSearch  = srchEn;
  end

endmodule

// File: rtl/lookup_prio_enc.sv
module lookup_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     reqVec,
  output logic [N-1:0]     grantVec,
  output logic [IDX_W-1:0] grantIdx,
  output logic             anyReq
);

  // lowerAny[i] is set when any request below i is active
  logic [N:0] lowerAny;

  assign lowerAny[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign lowerAny[i+1] = lowerAny[i] | reqVec[i];
    assign grantVec[i]   = reqVec[i] & ~lowerAny[i];
  end

  assign anyReq = lowerAny[N];

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (grantVec[i]) grantIdx = grantIdx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/lookup_datapath.sv
module lookup_datapath
  import assoc_lookup_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 16,
  parameter int DATA_W  = 12,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  lookupStrobes_t    strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  input  logic [KEY_W-1:0]  srchKey,
  output logic              hitOut,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [DATA_W-1:0] hitData
);

  logic [KEY_W-1:0]  keyStore  [ENTRIES];
  logic [DATA_W-1:0] dataStore [ENTRIES];
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] grantVec;
  logic [IDX_W-1:0]   winIdx;
  logic               anyMatch;
  logic [DATA_W-1:0]  selData;

  // entry storage, one generate slice per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic thisWrite;
    logic [KEY_W-1:0] bitEq;

    assign thisWrite = strobes.storeEntry && (wrIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[e] <= 1'b0;
      end else if (thisWrite) begin
        validVec[e] <= wrValid;
      end
    end

    always_ff @(posedge clk) begin
      if (thisWrite) begin
        keyStore[e]  <= wrKey;
        dataStore[e] <= wrData;
      end
    end

    // match line: starts true, any unequal bit pulls it low
    assign bitEq       = ~(keyStore[e] ^ srchKey);
    assign matchVec[e] = validVec[e] & (&bitEq);

    // R3: a raised match line means the full key is equal
    p_match_exact_r3: assert property (@(posedge clk) disable iff (!rstN)
      matchVec[e] |-> (keyStore[e] == srchKey));
  end

  lookup_prio_enc #(
    .N    (ENTRIES),
    .IDX_W(IDX_W)
  ) u_prio (
    .reqVec  (matchVec),
    .grantVec(grantVec),
    .grantIdx(winIdx),
    .anyReq  (anyMatch)
  );

  // grant line acts as word select of the data RAM
  always_comb begin
    selData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      selData = selData | (dataStore[i] & {DATA_W{grantVec[i]}});
    end
  end

  // registered result, captured only on a search
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitOut  <= 1'b0;
      hitIdx  <= '0;
      hitData <= '0;
    end else if (strobes.runSearch) begin
      hitOut  <= anyMatch;
      hitIdx  <= anyMatch ? winIdx : '0;
      hitData <= anyMatch ? selData : '0;
    end
  end

  // R4: at most one winner, and only among matching entries
  p_onehot_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantVec & ~matchVec) == '0));

  // R5: retired entries never raise a match line
  p_invalid_nomatch_r5: assert property (@(posedge clk) disable iff (!rstN)
    (matchVec & ~validVec) == '0);

  // R2: the hit flag after a search reflects the match lines of that cycle
  p_hit_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.runSearch |=> (hitOut == $past(|matchVec)));

  // R6: a miss drives index and data to zero
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !hitOut |-> (hitIdx == '0 && hitData == '0));

  // R8: results hold between searches
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.runSearch |=> ($stable(hitOut) && $stable(hitIdx) && $stable(hitData)));

endmodule

// File: rtl/assoc_lookup.sv
module assoc_lookup
  import assoc_lookup_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 16,
  parameter int DATA_W  = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  input  logic              srchEn,
  input  logic [KEY_W-1:0]  srchKey,
  output logic              hitOut,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [DATA_W-1:0] hitData
);

  lookupStrobes_t strobes;

  lookup_ctrl u_ctrl (
    .wrEn   (wrEn),
    .srchEn (srchEn),
    .strobes(strobes)
  );

  lookup_datapath #(
    .ENTRIES(ENTRIES),
    .KEY_W  (KEY_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrIdx  (wrIdx),
    .wrKey  (wrKey),
    .wrData (wrData),
    .wrValid(wrValid),
    .srchKey(srchKey),
    .hitOut (hitOut),
    .hitIdx (hitIdx),
    .hitData(hitData)
  );

endmodule

// File: tb/assoc_lookup_test.sv
`timescale 1ns/1ps
module assoc_lookup_test;

  localparam int ENTRIES = 8;
  localparam int KEY_W   = 16;
  localparam int DATA_W  = 12;
  localparam int IDX_W   = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [IDX_W-1:0]  wrIdx = '0;
  logic [KEY_W-1:0]  wrKey = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrValid = 1'b0;
  logic              srchEn = 1'b0;
  logic [KEY_W-1:0]  srchKey = '0;
  logic              hitOut;
  logic [IDX_W-1:0]  hitIdx;
  logic [DATA_W-1:0] hitData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assoc_lookup #(
    .ENTRIES(ENTRIES),
    .KEY_W  (KEY_W),
    .DATA_W (DATA_W)
  ) uut (
    .clk, .rstN, .wrEn, .wrIdx, .wrKey, .wrData, .wrValid,
    .srchEn, .srchKey, .hitOut, .hitIdx, .hitData
  );

  task automatic check(input string tag, input longint got, input longint exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic checkResult(input string tag, input bit h, input int idx, input int dat);
    check({tag, " hit"}, hitOut, h);
    check({tag, " idx"}, hitIdx, idx);
    check({tag, " data"}, hitData, dat);
  endtask

  task automatic writeEntry(input int idx, input int key, input int dat, input bit vld);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrKey = KEY_W'(key);
    wrData = DATA_W'(dat); wrValid = vld;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // strobe one search; result sampled one edge later
  task automatic search(input int key);
    @(negedge clk);
    srchEn = 1'b1; srchKey = KEY_W'(key);
    @(negedge clk);
    srchEn = 1'b0;
  endtask

  task automatic t_reset();
    checkResult("R1 reset", 0, 0, 0);
    search(16'h0000);
    checkResult("R1 search zero after reset", 0, 0, 0);
    search(16'hFFFF);
    checkResult("R1 search ones after reset", 0, 0, 0);
  endtask

  task automatic t_basic();
    writeEntry(3, 16'hA5C3, 12'h123, 1);
    search(16'hA5C3);
    checkResult("R2 exact match", 1, 3, 12'h123);
  endtask

  task automatic t_bitflip();
    search(16'hA5C2);   // stored bit0=1, key bit0=0
    checkResult("R3 flip 1to0 / R6 miss", 0, 0, 0);
    search(16'hA5C7);   // stored bit2=0, key bit2=1
    checkResult("R3 flip 0to1 / R6 miss", 0, 0, 0);
    search(16'h25C3);   // top bit differs
    checkResult("R3 flip msb", 0, 0, 0);
  endtask

  task automatic t_priority();
    writeEntry(6, 16'h0F0F, 12'h666, 1);
    writeEntry(1, 16'h0F0F, 12'h111, 1);
    search(16'h0F0F);
    checkResult("R4 two matches lowest wins", 1, 1, 12'h111);
    writeEntry(1, 16'h0F0F, 12'h000, 0);
    search(16'h0F0F);
    checkResult("R5 retired entry skipped", 1, 6, 12'h666);
  endtask

  task automatic t_hold();
    @(negedge clk);
    srchKey = 16'hA5C3;
    repeat (3) @(negedge clk);
    checkResult("R8 hold without strobe", 1, 6, 12'h666);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd4; wrKey = 16'h7777; wrData = 12'h444; wrValid = 1'b1;
    srchEn = 1'b1; srchKey = 16'h7777;
    @(negedge clk);
    wrEn = 1'b0; srchEn = 1'b0;
    checkResult("R7 new key unseen in same cycle", 0, 0, 0);
    search(16'h7777);
    checkResult("R7 new key seen next search", 1, 4, 12'h444);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd3; wrKey = 16'hBEEF; wrData = 12'h0EF; wrValid = 1'b1;
    srchEn = 1'b1; srchKey = 16'hA5C3;
    @(negedge clk);
    wrEn = 1'b0; srchEn = 1'b0;
    checkResult("R7 old key still hits in same cycle", 1, 3, 12'h123);
  endtask

  task automatic t_overwrite();
    search(16'hA5C3);
    checkResult("R9 old key gone", 0, 0, 0);
    search(16'hBEEF);
    checkResult("R9 new key and data", 1, 3, 12'h0EF);
    search(16'h0F0F);
    checkResult("R9 other entry untouched", 1, 6, 12'h666);
  endtask

  task automatic t_edges();
    writeEntry(7, 16'h1234, 12'h777, 1);
    search(16'h1234);
    checkResult("R2 last entry", 1, 7, 12'h777);
    writeEntry(0, 16'h1234, 12'h0AB, 1);
    search(16'h1234);
    checkResult("R4 entry zero beats last", 1, 0, 12'h0AB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bitflip();
    t_priority();
    t_hold();
    t_same_cycle();
    t_overwrite();
    t_edges();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule